// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This unit keeps the status word of a floating-point pipeline. Each time an arithmetic operation completes, the five IEEE exception flags it raised are written into a current-exception field. The unit then decides between two outcomes. If any of those flags is also enabled in the trap-enable field, it records an IEEE trap type and pulses a trap request to the sequencer. If none is enabled, it folds the flags into a sticky accrued field.

Software can overwrite the status word through a load port. Only the writable fields change, and every other bit keeps its previous value. A clear command wipes the current-exception field. The two-bit rounding-direction field is decoded continuously into a rounding-mode output for the arithmetic datapath.

Top module: `fpx_status_unit`

## Requirements
- R1: After a synchronous reset the status word is 0x00000000, `trap_req` is low and `rnd_mode` is 00.
- R2: When `op_done` is high, the current-exception field, status bits [4:0], takes the value of `op_flags`. The flag bits are: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact.
- R3: A trap is taken when, for some i, `op_flags[i]` and trap-enable bit [23+i] are both set. The enable field occupies status bits [27:23].
- R4: On a trap, three things happen. The trap-type field, bits [16:14], becomes 3'b001. The accrued field is left unchanged. `trap_req` is high for the one cycle that follows the completing edge.
- R5: Without a trap, the accrued field, bits [9:5], is ORed with `op_flags`, and the trap-type field is cleared to 3'b000.
- R6: `rnd_mode` follows the rounding field, bits [31:30]: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. It is valid in the cycle after a load.
- R7: A load replaces only the bits in the write mask 0xCF8003FF (rounding, enables, accrued, current). The trap-type field and the reserved bits keep their old values.
- R8: `clr_flags` zeroes the current-exception field and leaves the accrued field unchanged.
- R9: Priority is load over operation, and operation over clear. An operation that coincides with a load is dropped and raises no trap.
- R10: An operation with all flags clear zeroes the current field, leaves the accrued field unchanged and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | Arithmetic operation completed this cycle |
| op_flags | input | 5 | Exception flags of that operation |
| clr_flags | input | 1 | Clear the current-exception field |
| ld_en | input | 1 | Software load of the status word |
| ld_data | input | 32 | Data for the load |
| status | output | 32 | Status word |
| rnd_mode | output | 2 | Decoded rounding direction |
| trap_req | output | 1 | One-cycle IEEE exception trap request |

## Verification
Two collisions can occur in the same cycle: a software load against a completing operation, and a completing operation against a clear command. Both are provoked by driving the two strobes on the same edge.

In the first collision the operation carries a flag that would trap. The check expects the loaded word, with the trap-type field unchanged, and `trap_req` low. In the second collision the check expects the new flags in the current field and their OR into the accrued field, as though the clear had never been issued.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_W  = 5;
    localparam int REG_W   = 32;
    localparam int CUR_LSB = 0;
    localparam int ACC_LSB = 5;
    localparam int TT_LSB  = 14;
    localparam int TT_W    = 3;
    localparam int TEN_LSB = 23;
    localparam int RND_LSB = 30;
    localparam int RND_W   = 2;

    localparam logic [TT_W-1:0] TT_NONE = 3'd0;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef logic [FLAG_W-1:0] flags_t;
    typedef logic [REG_W-1:0]  word_t;

    typedef enum logic [RND_W-1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_UP   = 2'b10,
        RND_DOWN = 2'b11
    } rnd_e;

    typedef struct packed {
        flags_t          cur_next;
        flags_t          acc_next;
        logic [TT_W-1:0] tt_next;
        logic            trap;
    } eval_t;

    function automatic word_t field_mask(input int lsb, input int w);
        word_t m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lsb && i < lsb + w) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam word_t WR_MASK = field_mask(CUR_LSB, FLAG_W) | field_mask(ACC_LSB, FLAG_W)
                              | field_mask(TEN_LSB, FLAG_W) | field_mask(RND_LSB, RND_W);

    function automatic rnd_e decode_rnd(input logic [RND_W-1:0] f);
        rnd_e r;
        case (f)
            2'b00:   r = RND_NEAR;
            2'b01:   r = RND_ZERO;
            2'b10:   r = RND_UP;
            default: r = RND_DOWN;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
    import fpx_pkg::*;
(
    input  word_t  status_i,
    input  flags_t flags_i,
    output eval_t  eval_o
);
    flags_t en_aligned;
    flags_t hits;
    word_t  acc_word;

    always_comb begin
        en_aligned = flags_t'(status_i >> (TEN_LSB - CUR_LSB));
        hits       = flags_i & en_aligned;
        acc_word   = status_i | (word_t'(flags_i) << ACC_LSB);

        eval_o.cur_next = flags_i;
        eval_o.trap     = |hits;
        if (|hits) begin
            eval_o.acc_next = status_i[ACC_LSB +: FLAG_W];
            eval_o.tt_next  = TT_IEEE;
        end else begin
            eval_o.acc_next = acc_word[ACC_LSB +: FLAG_W];
            eval_o.tt_next  = TT_NONE;
        end
    end
endmodule

// File: rtl/fpx_load_merge.sv
module fpx_load_merge
    import fpx_pkg::*;
(
    input  word_t old_i,
    input  word_t new_i,
    output word_t merged_o
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (WR_MASK[b]) begin : g_wr
            assign merged_o[b] = new_i[b];
        end else begin : g_keep
            assign merged_o[b] = old_i[b];
        end
    end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_done,
    input  logic [4:0]  op_flags,
    input  logic        clr_flags,
    input  logic        ld_en,
    input  logic [31:0] ld_data,
    output logic [31:0] status,
    output logic [1:0]  rnd_mode,
    output logic        trap_req
);
    word_t stat_q, stat_d, merged;
    eval_t ev;
    logic  trap_d, trap_q;

    fpx_trap_eval u_eval (
        .status_i (stat_q),
        .flags_i  (op_flags),
        .eval_o   (ev)
    );

    fpx_load_merge u_merge (
        .old_i    (stat_q),
        .new_i    (ld_data),
        .merged_o (merged)
    );

    always_comb begin
        stat_d = stat_q;
        trap_d = 1'b0;
        if (ld_en) begin
            stat_d = merged;
        end else if (op_done) begin
            stat_d[CUR_LSB +: FLAG_W] = ev.cur_next;
            stat_d[ACC_LSB +: FLAG_W] = ev.acc_next;
            stat_d[TT_LSB +: TT_W]    = ev.tt_next;
            trap_d                    = ev.trap;
        end else if (clr_flags) begin
            stat_d[CUR_LSB +: FLAG_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            trap_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            trap_q <= trap_d;
        end
    end

    assign status   = stat_q;
    assign trap_req = trap_q;
    assign rnd_mode = decode_rnd(stat_q[RND_LSB +: RND_W]);

    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(op_done && !ld_en)); // R4
    AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (status[TT_LSB +: TT_W] == TT_IEEE)); // R4
    AST_TRAP_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (status[ACC_LSB +: FLAG_W] == $past(status[ACC_LSB +: FLAG_W]))); // R4
    AST_TRAP_ENABLED: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> ((status[CUR_LSB +: FLAG_W] & status[TEN_LSB +: FLAG_W]) != '0)); // R3
    AST_ACC_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_en) |-> (($past(status[ACC_LSB +: FLAG_W]) & ~status[ACC_LSB +: FLAG_W]) == '0)); // R5
    AST_LOAD_KEEPS_TT: assert property (@(posedge clk) disable iff (rst)
        $past(ld_en) |-> (status[TT_LSB +: TT_W] == $past(status[TT_LSB +: TT_W]))); // R7
    AST_LOAD_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        $past(ld_en) |-> !trap_req); // R9
endmodule

// File: tb/test_fpx_status_unit.sv
module test_fpx_status_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        clr_flags = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] status;
    logic [1:0]  rnd_mode;
    logic        trap_req;

    typedef struct {
        logic [31:0] st;
        logic        tr;
        logic [1:0]  rm;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_st = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fpx_status_unit i_fpx_status_unit (
        .clk(clk), .rst(rst), .op_done(op_done), .op_flags(op_flags),
        .clr_flags(clr_flags), .ld_en(ld_en), .ld_data(ld_data),
        .status(status), .rnd_mode(rnd_mode), .trap_req(trap_req)
    );

    task automatic drive(input logic op, input logic [4:0] f, input logic clr,
                         input logic ld, input logic [31:0] d, input string tag);
        exp_t        e;
        logic        hit;
        logic [31:0] wm;
        @(negedge clk);
        op_done = op; op_flags = f; clr_flags = clr; ld_en = ld; ld_data = d;
        wm  = 32'hCF8003FF;
        hit = 1'b0;
        if (ld) begin
            m_st = (d & wm) | (m_st & ~wm);
        end else if (op) begin
            hit = |(f & m_st[27:23]);
            m_st[4:0] = f;
            if (hit) m_st[16:14] = 3'b001;
            else begin
                m_st[16:14] = 3'b000;
                m_st[9:5]   = m_st[9:5] | f;
            end
        end else if (clr) begin
            m_st[4:0] = 5'b0;
        end
        e.st = m_st; e.tr = hit; e.rm = m_st[31:30]; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (status !== e.st || trap_req !== e.tr || rnd_mode !== e.rm) begin
                    n_fail++;
                    $display("FAIL %s: status=%h trap=%b rnd=%b expected status=%h trap=%b rnd=%b",
                             e.tag, status, trap_req, rnd_mode, e.st, e.tr, e.rm);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(0, 5'b00000, 0, 0, 32'h0, "R1 reset state");
        drive(1, 5'b00001, 0, 0, 32'h0, "R2 R5 inexact accrues");
        drive(1, 5'b10100, 0, 0, 32'h0, "R2 R5 invalid+underflow accrue");
        drive(1, 5'b00000, 0, 0, 32'h0, "R10 empty flags");
        drive(0, 5'b00000, 0, 1, 32'hFFFFFFFF, "R7 R6 load all ones");
        drive(0, 5'b00000, 0, 1, 32'h44000000, "R7 R6 load overflow enable, toward zero");
        drive(1, 5'b01000, 0, 0, 32'h0, "R3 R4 overflow traps");
        drive(0, 5'b00000, 0, 0, 32'h0, "R4 trap lasts one cycle");
        drive(1, 5'b00001, 0, 0, 32'h0, "R3 R5 disabled flag accrues");
        drive(0, 5'b00000, 1, 0, 32'h0, "R8 clear current field");
        drive(1, 5'b00010, 1, 0, 32'h0, "R9 op beats clear");
        drive(1, 5'b01000, 0, 1, 32'h80000000, "R9 R6 load beats trapping op");
        drive(0, 5'b00000, 0, 1, 32'h0F800000, "R7 enable all");
        drive(1, 5'b10000, 0, 0, 32'h0, "R3 R4 invalid traps");
        drive(1, 5'b00100, 0, 0, 32'h0, "R4 back-to-back trap");
        drive(0, 5'b00000, 0, 1, 32'h0011C000, "R7 read-only bits kept");
        drive(0, 5'b00000, 0, 1, 32'h00000000, "R6 nearest after load");
        drive(1, 5'b11111, 0, 0, 32'h0, "R2 R5 all flags accrue");
        drive(0, 5'b00000, 0, 0, 32'h0, "R8 idle hold");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule